// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures how fast a fan turns. It counts ticks of a slow timebase between two rising edges of the fan's tachometer signal. The tachometer input is asynchronous, so it is first synchronized and edge-detected. The timebase is taken from a 50 kHz system clock. It can be divided by 16, 8, 4 or 2, which gives 3.125 kHz, 6.25 kHz, 12.5 kHz or 25 kHz. A slow fan gives a large count and a fast fan gives a small one.

Only the most recent complete measurement can be read. The count stops at 255. A fan that has stopped or is far too slow therefore reads 255. If the fault enable is set, the same condition raises a fault flag. The flag stays set until the clear strobe is pulsed. The timebase divider restarts at every detected edge, so each period is counted from a known phase. The first edge after reset only starts a measurement.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset, period_o is 0 and fault_o is 0.
- R2: The rate select chooses the tick divisor as follows: 0 gives divide by 16, 1 gives divide by 8, 2 gives divide by 4 and 3 gives divide by 2 (system clock cycles per tick).
- R3: If P clock cycles pass between two rising edges of tach_i, period_o becomes floor(P / divisor) when that value is 255 or less. period_o updates at the third rising clock edge after the rise of tach_i. Falling edges of tach_i do not complete a measurement.
- R4: The first rising edge of tach_i after reset starts a measurement but leaves period_o unchanged.
- R5: period_o keeps its last completed value while no new rising edge of tach_i arrives and the count stays at or below 255.
- R6: A period of exactly 255 ticks reads 255 and does not raise a fault.
- R7: If the count would pass 255, it stays at 255. When that happens, period_o becomes 255 even if no edge has arrived. It stays 255 until a rising edge completes a measurement.
- R8: When fault_en_i is 1, a count that would pass 255 sets fault_o. When fault_en_i is 0, no fault is raised.
- R9: fault_o stays set, even after fault_en_i goes to 0, until fault_clr_i is 1 in a cycle without a new overflow. A new overflow in the same cycle takes priority over the clear.
- R10: Before the first rising edge of tach_i after reset, nothing is counted and no fault is raised, whatever the rate and enable are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 kHz system oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tach_i | input | 1 | Asynchronous tachometer pulse from the fan |
| rate_sel_i | input | 2 | Timebase select, 0 = divide by 16 up to 3 = divide by 2 |
| fault_en_i | input | 1 | 1 allows an overflow to set the fault |
| fault_clr_i | input | 1 | Strobe that clears a sticky fault |
| period_o | output | 8 | Last completed period in timebase ticks, saturating at 255 |
| fault_o | output | 1 | Sticky overflow fault |

## Verification
A wrong divisor or a divider that is not restarted at each edge shows up as a wrong period_o. The error appears on the first full measurement after the rate is set, which is three clock cycles after the second edge. A counter that wraps instead of saturating would read a small value after a stall. The stall check catches this within about 512 cycles at the fastest rate. A sticky flag that leaks would show as fault_o dropping when fault_en_i falls before any clear strobe. A missed arm state would show as a nonzero period_o after only one edge.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

   // log2 of the tick divisor for a rate select code; code 0 is the slowest rate
   function automatic int unsigned rate_shift(input int unsigned sel,
                                              input int unsigned min_shift,
                                              input int unsigned n_rates);
      return min_shift + (n_rates - 1 - sel);
   endfunction

endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tach_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tach_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] pipe_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-1:0], tach_i};
   end

   assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

   // R3
   rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);

endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
   parameter int unsigned RATE_W    = 2,
   parameter int unsigned MIN_SHIFT = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [RATE_W-1:0] rate_sel_i,
   input  logic              restart_i,
   output logic              tick_o
);

   localparam int unsigned NUM_RATES = 1 << RATE_W;
   localparam int unsigned PRE_W     = MIN_SHIFT + NUM_RATES - 1;

   if (MIN_SHIFT < 1) begin : g_bad_shift
      $error("tach_prescaler: MIN_SHIFT must be at least 1");
   end

   logic [PRE_W-1:0] mask_tbl [NUM_RATES];

   for (genvar g = 0; g < NUM_RATES; g++) begin : g_mask
      localparam int unsigned SH = fan_tach_pkg::rate_shift(g, MIN_SHIFT, NUM_RATES);
      assign mask_tbl[g] = PRE_W'((64'd1 << SH) - 64'd1);
   end

   logic [PRE_W-1:0] div_q;
   logic [PRE_W-1:0] mask;

   assign mask = mask_tbl[rate_sel_i];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        div_q <= '0;
      else if (restart_i) div_q <= '0;
      else                div_q <= div_q + 1'b1;
   end

   assign tick_o = ((div_q & mask) == mask);

   // R2
   tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);

endmodule

// File: rtl/tach_counter.sv
module tach_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rise_i,
   input  logic             tick_i,
   input  logic             fault_en_i,
   input  logic             fault_clr_i,
   output logic [CNT_W-1:0] period_o,
   output logic             fault_o
);

   if (CNT_W < 2) begin : g_bad_width
      $error("tach_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] result_q;
   logic             fault_q;
   logic             at_max;
   logic             ovf_evt;
   logic [CNT_W-1:0] cnt_sat;

   assign at_max  = (cnt_q == CNT_MAX);
   assign ovf_evt = armed_q & tick_i & at_max;
   assign cnt_sat = (tick_i && !at_max) ? cnt_q + 1'b1 : cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (rise_i) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (armed_q && tick_i && !at_max) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                result_q <= '0;
      else if (rise_i && armed_q) result_q <= cnt_sat;
      else if (ovf_evt)           result_q <= CNT_MAX;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    fault_q <= 1'b0;
      else if (ovf_evt && fault_en_i) fault_q <= 1'b1;
      else if (fault_clr_i)           fault_q <= 1'b0;
   end

   assign period_o = result_q;
   assign fault_o  = fault_q;

   // R5
   result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rise_i && !tick_i) |=> $stable(period_o));

   // R9
   fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_o && !fault_clr_i) |=> fault_o);

   // R8
   fault_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fault_o && !fault_en_i) |=> !fault_o);

   // R10
   unarmed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!armed_q && !rise_i) |=> (period_o == '0 && !fault_o));

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned RATE_W      = 2,
   parameter int unsigned MIN_SHIFT   = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tach_i,
   input  logic [RATE_W-1:0] rate_sel_i,
   input  logic              fault_en_i,
   input  logic              fault_clr_i,
   output logic [CNT_W-1:0]  period_o,
   output logic              fault_o
);

   if (RATE_W < 1) begin : g_bad_rate
      $error("fan_tach_meter: RATE_W must be at least 1");
   end

   logic rise;
   logic tick;

   tach_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tach_i (tach_i),
      .rise_o (rise)
   );

   tach_prescaler #(.RATE_W(RATE_W), .MIN_SHIFT(MIN_SHIFT)) u_pre (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rate_sel_i (rate_sel_i),
      .restart_i  (rise),
      .tick_o     (tick)
   );

   tach_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rise_i      (rise),
      .tick_i      (tick),
      .fault_en_i  (fault_en_i),
      .fault_clr_i (fault_clr_i),
      .period_o    (period_o),
      .fault_o     (fault_o)
   );

endmodule

// File: tb/fan_tach_meter_test.sv
`timescale 1ns/1ps
module fan_tach_meter_test;

   localparam time CLK_PERIOD = 20us;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tach = 1'b0;
   logic [1:0] sel = 2'd0;
   logic       fen = 1'b0;
   logic       fclr = 1'b0;
   logic [7:0] period;
   logic       fault;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fan_tach_meter uut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .tach_i      (tach),
      .rate_sel_i  (sel),
      .fault_en_i  (fen),
      .fault_clr_i (fclr),
      .period_o    (period),
      .fault_o     (fault)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tach_edges(input int n, input int p);
      for (int i = 0; i < n; i++) begin
         tach = 1'b1;
         repeat (p/2) @(negedge clk);
         tach = 1'b0;
         repeat (p - p/2) @(negedge clk);
      end
   endtask

   task automatic t_reset;
      check("R1 period", period, 0);
      check("R1 fault", fault, 0);
   endtask

   task automatic t_unarmed;
      sel = 2'd3; fen = 1'b1;
      repeat (3000) @(negedge clk);
      check("R10 period", period, 0);
      check("R10 fault", fault, 0);
      fen = 1'b0;
   endtask

   task automatic t_arm_and_slow;
      sel = 2'd0;
      tach_edges(1, 160);
      check("R4 first edge", period, 0);
      tach_edges(2, 160);
      check("R3 R2 div16", period, 10);
      repeat (50) @(negedge clk);
      check("R5 hold", period, 10);
   endtask

   task automatic t_rates;
      sel = 2'd3; tach_edges(3, 100);
      check("R2 div2", period, 50);
      sel = 2'd2; tach_edges(3, 100);
      check("R2 div4", period, 25);
      sel = 2'd1; tach_edges(3, 100);
      check("R3 div8 floor", period, 12);
      sel = 2'd2; tach_edges(2, 60);
      check("R3 short period", period, 15);
   endtask

   task automatic t_stall;
      sel = 2'd3; fen = 1'b0;
      repeat (600) @(negedge clk);
      check("R7 stall value", period, 255);
      check("R8 disabled", fault, 0);
      fen = 1'b1;
      repeat (10) @(negedge clk);
      check("R8 enabled", fault, 1);
      fen = 1'b0;
      repeat (10) @(negedge clk);
      check("R9 sticky", fault, 1);
      fclr = 1'b1;
      @(negedge clk);
      fclr = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 cleared", fault, 0);
   endtask

   task automatic t_boundary;
      sel = 2'd3; fen = 1'b0;
      tach_edges(1, 510);
      fen = 1'b1;
      tach_edges(2, 510);
      check("R6 exact max value", period, 255);
      check("R6 exact max no fault", fault, 0);
      tach_edges(2, 512);
      check("R7 saturated value", period, 255);
      check("R8 overflow fault", fault, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unarmed();
      t_arm_and_slow();
      t_rates();
      t_stall();
      t_boundary();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule